// File: doc/BRIEF.md
# Chain-Descriptor DMA Walker

This block is the control engine of one memory-to-peripheral DMA channel that works through a linked list of descriptors held in memory. A pulse on `start_i` gives it the byte address of the first descriptor. The block reads each 64-bit descriptor through a request/response port and decodes its operation code. Where the descriptor carries data, the block issues one block-transfer command to an external data mover and waits until the mover reports that it has finished. It then works out where the next descriptor is.

Each descriptor holds several fields. Its data or link address is in bits 63:32. Bit 31 is an interrupt-stop flag. Bits 30:28 hold the operation code, and bits 15:0 give a length in 16-byte quadwords. A two-entry stack of return addresses lets a list descend into sub-lists and come back, with nesting up to two levels deep. The walk ends with `done_o` when it stops normally and with `error_o` when it finds a fault. Both flags hold until the next start.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `tag_req_o` and `xfer_req_o` are 0, and `stack_depth_o` and `last_tag_hi_o` are 0.
- R2: A descriptor is fetched by raising `tag_req_o` with `tag_addr_o` set to its byte address. Both stay unchanged until a cycle with `tag_valid_i` high, and in that cycle `tag_data_i` is taken. The first fetch uses `start_addr_i`. The two request outputs are never high together.
- R3: The data block of codes 1, 2, 5, 6 and 7 starts at descriptor address + 16. The data block of codes 0, 3 and 4 starts at the address field. For each descriptor with a nonzero length, one command is issued on `xfer_addr_o`/`xfer_qwc_o`, and it is held until `xfer_done_i`. A length of 0 issues no command.
- R4: The next descriptor is found by operation code. Code 1 goes to the address after the data (the data start plus 16 × length). Code 2 goes to the address field. Codes 3 and 4 go to descriptor address + 16. Codes 0 and 7 stop after their data.
- R5: Code 5 pushes the address after its data and goes on at the address field. Code 6 pops the stack and goes on at the popped address, or stops (done) when the stack is empty. `stack_depth_o` reports the entries held (0 to 2) and is cleared by an accepted start.
- R6: Code 5 with two entries already on the stack stops the walk with `error_o`. No transfer is issued for that descriptor.
- R7: Codes 0, 2, 3, 4 and 5 use the address field. If any of its bits 3:0 is set, the walk stops with `error_o` and issues no transfer for that descriptor. A start address with any of bits 3:0 set raises `error_o` without any fetch.
- R8: When bit 31 of a descriptor is set and `tag_irq_en_i` is 1, the walk stops with `done_o` after that descriptor's data. When `tag_irq_en_i` is 0, the bit has no effect.
- R9: `last_tag_hi_o` holds bits 31:16 of the last descriptor accepted.
- R10: `busy_o` is high from the accepted start to the stop. `done_o` and `error_o` are never both high. They are cleared by the next accepted start.
- R11: A start pulse while `busy_o` is high is ignored, and the walk in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_addr_i | input | 32 | Byte address of the first descriptor |
| tag_irq_en_i | input | 1 | Enables the interrupt-stop flag in descriptors |
| tag_req_o | output | 1 | Descriptor read request |
| tag_addr_o | output | 32 | Byte address of the descriptor being read |
| tag_valid_i | input | 1 | Descriptor read response valid |
| tag_data_i | input | 64 | Descriptor read data |
| xfer_req_o | output | 1 | Block-transfer command valid |
| xfer_addr_o | output | 32 | Byte address of the data block |
| xfer_qwc_o | output | 16 | Length of the data block in quadwords |
| xfer_done_i | input | 1 | Data mover has finished the command |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk stopped normally |
| error_o | output | 1 | Walk stopped on a fault |
| last_tag_hi_o | output | 16 | Bits 31:16 of the last descriptor accepted |
| stack_depth_o | output | 2 | Return-address entries held |

## Verification
Several rules are checked on every cycle: the request-holding rules of both handshakes, that the two request outputs are never high together, that every issued and fetched address is aligned, the bound on stack depth, and that the stop flags match the idle state. Other behaviour shows only in the bench's scenarios, which compare the full walk against a model run over the same memory image. That covers which address each operation code picks, the order of pushes and pops in nested sub-lists, the stack-overflow and misalignment faults, the interrupt-stop flag, and a start that is ignored during a walk.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int TAG_W   = 64;
  localparam int ADDR_W  = 32;
  localparam int QWC_W   = 16;
  localparam int QW_LOG2 = 4;

  typedef enum logic [2:0] {
    OP_REF_STOP = 3'd0,
    OP_COUNT    = 3'd1,
    OP_JUMP     = 3'd2,
    OP_REF      = 3'd3,
    OP_REF_STALL= 3'd4,
    OP_CALL     = 3'd5,
    OP_RETURN   = 3'd6,
    OP_STOP     = 3'd7
  } tag_op_e;

  typedef enum logic [1:0] {
    W_IDLE, W_FETCH, W_DECODE, W_MOVE
  } walk_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] data_addr;
    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] push_addr;
    logic [QWC_W-1:0]  qwc;
    logic              push;
    logic              pop;
    logic              stop;
    logic              fault;
  } tag_plan_t;
endpackage

// File: rtl/dma_ret_stack.sv
module dma_ret_stack #(
  parameter int DEPTH = 2,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  push_val,
  output logic [W-1:0]  top,
  output logic [PW-1:0] ptr,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (push && !full && !clear) slot[IW'(ptr)] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)          ptr <= '0;
    else if (push && !full)    ptr <= ptr + PW'(1);
    else if (pop && !empty)    ptr <= ptr - PW'(1);
  end

  assign full  = (ptr == PW'(DEPTH));
  assign empty = (ptr == '0);
  assign top   = slot[IW'(ptr - PW'(1))];
endmodule

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
  import dma_chain_pkg::*;
(
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ADDR_W-1:0] tag_addr_i,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic              irq_en_i,
  output tag_plan_t         plan_o
);
  logic [ADDR_W-1:0] field, after_tag, after_data;
  logic [QWC_W-1:0]  qwc;
  tag_op_e           op;
  logic              uses_field;
  logic [11:0]       unused_mid;

  assign field      = tag_i[63:32];
  assign op         = tag_op_e'(tag_i[30:28]);
  assign qwc        = tag_i[QWC_W-1:0];
  assign unused_mid = tag_i[27:16];
  assign after_tag  = tag_addr_i + ADDR_W'(1 << QW_LOG2);
  assign after_data = after_tag + (ADDR_W'(qwc) << QW_LOG2);

  always_comb begin
    plan_o           = '0;
    plan_o.qwc       = qwc;
    plan_o.data_addr = after_tag;
    plan_o.next_addr = after_data;
    plan_o.push_addr = after_data;
    uses_field       = 1'b0;
    unique case (op)
      OP_REF_STOP: begin plan_o.data_addr = field; uses_field = 1'b1; plan_o.stop = 1'b1; end
      OP_COUNT:    ;
      OP_JUMP:     begin plan_o.next_addr = field; uses_field = 1'b1; end
      OP_REF, OP_REF_STALL: begin
        plan_o.data_addr = field; plan_o.next_addr = after_tag; uses_field = 1'b1;
      end
      OP_CALL: begin
        plan_o.next_addr = field; uses_field = 1'b1;
        plan_o.push = 1'b1; plan_o.fault = full_i;
      end
      OP_RETURN: begin
        if (empty_i) plan_o.stop = 1'b1;
        else begin plan_o.pop = 1'b1; plan_o.next_addr = top_i; end
      end
      OP_STOP:     plan_o.stop = 1'b1;
      default:     ;
    endcase
    if (uses_field && (field[QW_LOG2-1:0] != '0)) plan_o.fault = 1'b1;
    if (tag_i[31] && irq_en_i) plan_o.stop = 1'b1;
  end
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import dma_chain_pkg::*;
#(
  parameter int STACK_DEPTH = 2,
  localparam int PW = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              tag_irq_en_i,
  output logic              tag_req_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_valid_i,
  input  logic [TAG_W-1:0]  tag_data_i,
  output logic              xfer_req_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [QWC_W-1:0]  xfer_qwc_o,
  input  logic              xfer_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [15:0]       last_tag_hi_o,
  output logic [PW-1:0]     stack_depth_o
);
  walk_state_e       state;
  logic [TAG_W-1:0]  tag_r;
  logic [ADDR_W-1:0] next_r, top;
  logic              stop_r, full, empty;
  logic              stk_clear, stk_push, stk_pop;
  tag_plan_t         plan;
  logic              go_stop;
  logic [ADDR_W-1:0] go_next;

  dma_tag_decode u_dec (
    .tag_i(tag_r), .tag_addr_i(tag_addr_o), .full_i(full), .empty_i(empty),
    .top_i(top), .irq_en_i(tag_irq_en_i), .plan_o(plan)
  );

  assign stk_clear = (state == W_IDLE) && start_i;
  assign stk_push  = (state == W_DECODE) && plan.push && !plan.fault;
  assign stk_pop   = (state == W_DECODE) && plan.pop && !plan.fault;

  dma_ret_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stk (
    .clk(clk), .rst(rst), .clear(stk_clear), .push(stk_push), .pop(stk_pop),
    .push_val(plan.push_addr), .top(top), .ptr(stack_depth_o),
    .full(full), .empty(empty)
  );

  always_comb begin
    go_stop = (state == W_DECODE) ? plan.stop : stop_r;
    go_next = (state == W_DECODE) ? plan.next_addr : next_r;
  end

  assign busy_o = (state != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= W_IDLE;
      tag_req_o     <= 1'b0;
      tag_addr_o    <= '0;
      xfer_req_o    <= 1'b0;
      xfer_addr_o   <= '0;
      xfer_qwc_o    <= '0;
      done_o        <= 1'b0;
      error_o       <= 1'b0;
      last_tag_hi_o <= '0;
      tag_r         <= '0;
      next_r        <= '0;
      stop_r        <= 1'b0;
    end else begin
      unique case (state)
        W_IDLE: if (start_i) begin
          done_o  <= 1'b0;
          error_o <= 1'b0;
          if (start_addr_i[QW_LOG2-1:0] != '0) error_o <= 1'b1;
          else begin
            tag_addr_o <= start_addr_i;
            tag_req_o  <= 1'b1;
            state      <= W_FETCH;
          end
        end
        W_FETCH: if (tag_valid_i) begin
          tag_r         <= tag_data_i;
          last_tag_hi_o <= tag_data_i[31:16];
          tag_req_o     <= 1'b0;
          state         <= W_DECODE;
        end
        W_DECODE: begin
          next_r <= plan.next_addr;
          stop_r <= plan.stop;
          if (plan.fault) begin
            error_o <= 1'b1;
            state   <= W_IDLE;
          end else if (plan.qwc != '0) begin
            xfer_req_o  <= 1'b1;
            xfer_addr_o <= plan.data_addr;
            xfer_qwc_o  <= plan.qwc;
            state       <= W_MOVE;
          end else if (go_stop) begin
            done_o <= 1'b1;
            state  <= W_IDLE;
          end else begin
            tag_addr_o <= go_next;
            tag_req_o  <= 1'b1;
            state      <= W_FETCH;
          end
        end
        W_MOVE: if (xfer_done_i) begin
          xfer_req_o <= 1'b0;
          if (go_stop) begin
            done_o <= 1'b1;
            state  <= W_IDLE;
          end else begin
            tag_addr_o <= go_next;
            tag_req_o  <= 1'b1;
            state      <= W_FETCH;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk #(
  parameter int STACK_DEPTH = 2,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          tag_req_o,
  input logic [31:0]   tag_addr_o,
  input logic          tag_valid_i,
  input logic          xfer_req_o,
  input logic [31:0]   xfer_addr_o,
  input logic [15:0]   xfer_qwc_o,
  input logic          xfer_done_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          error_o,
  input logic [PW-1:0] stack_depth_o
);
  p_req_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(tag_req_o && xfer_req_o));
  p_tag_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (tag_req_o && !tag_valid_i) |=> (tag_req_o && $stable(tag_addr_o)));
  p_xfer_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req_o && !xfer_done_i) |=> (xfer_req_o && $stable(xfer_addr_o) && $stable(xfer_qwc_o)));
  p_xfer_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> (xfer_qwc_o != 16'd0));
  p_xfer_align_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_req_o |-> (xfer_addr_o[3:0] == 4'd0));
  p_tag_align_r7: assert property (@(posedge clk) disable iff (rst)
    tag_req_o |-> (tag_addr_o[3:0] == 4'd0));
  p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
    stack_depth_o <= PW'(STACK_DEPTH));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o || error_o) |-> !busy_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!tag_req_o && !xfer_req_o));
endmodule

bind dma_chain_walker dma_chain_walker_chk #(.STACK_DEPTH(STACK_DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .tag_req_o(tag_req_o), .tag_addr_o(tag_addr_o),
  .tag_valid_i(tag_valid_i), .xfer_req_o(xfer_req_o), .xfer_addr_o(xfer_addr_o),
  .xfer_qwc_o(xfer_qwc_o), .xfer_done_i(xfer_done_i), .busy_o(busy_o),
  .done_o(done_o), .error_o(error_o), .stack_depth_o(stack_depth_o)
);

// File: tb/dma_chain_walker_bench.sv
module dma_chain_walker_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, irq_en = 1'b0;
  logic [31:0] start_addr = '0;
  logic        tag_req, tag_valid = 1'b0, xfer_req, xfer_done = 1'b0;
  logic [31:0] tag_addr, xfer_addr;
  logic [63:0] tag_data = '0;
  logic [15:0] xfer_qwc, last_hi;
  logic        busy, done, error;
  logic [1:0]  depth;

  dma_chain_walker u_dma_chain_walker (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(start_addr),
    .tag_irq_en_i(irq_en), .tag_req_o(tag_req), .tag_addr_o(tag_addr),
    .tag_valid_i(tag_valid), .tag_data_i(tag_data), .xfer_req_o(xfer_req),
    .xfer_addr_o(xfer_addr), .xfer_qwc_o(xfer_qwc), .xfer_done_i(xfer_done),
    .busy_o(busy), .done_o(done), .error_o(error), .last_tag_hi_o(last_hi),
    .stack_depth_o(depth)
  );

  logic [63:0] mem [256];
  int checks = 0, errors = 0;
  logic [31:0] exp_a [64];
  logic [15:0] exp_q [64];
  int exp_n, got_n, exp_depth, wait_cnt;
  bit exp_done, exp_err, seen;
  logic [15:0] exp_hi = '0;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(int op, bit irq, logic [31:0] f, int q);
    return {f, irq, 3'(op), 12'h0, 16'(q)};
  endfunction

  // memory and data-mover responders
  always @(negedge clk) begin
    if (tag_valid) tag_valid = 1'b0;
    else if (tag_req) begin
      tag_data  = mem[tag_addr[11:4]];
      tag_valid = 1'b1;
    end
    if (xfer_done) xfer_done = 1'b0;
    else if (xfer_req) begin
      if (!seen) begin
        seen = 1'b1;
        wait_cnt = $urandom % 3;
        if (got_n < exp_n) begin
          check(xfer_addr == exp_a[got_n], "R3", "data address", xfer_addr, exp_a[got_n]);
          check(xfer_qwc == exp_q[got_n], "R3", "data length", xfer_qwc, exp_q[got_n]);
        end else check(1'b0, "R4", "unexpected transfer", xfer_addr, 0);
        got_n++;
      end
      if (wait_cnt == 0) begin xfer_done = 1'b1; seen = 1'b0; end
      else wait_cnt--;
    end
  end

  // reference walk over the memory image
  task automatic model(input logic [31:0] sa, input bit ie, output bit skip);
    logic [31:0] cur, f, at, ad, da, nx;
    logic [31:0] stk [2];
    logic [63:0] t;
    logic [15:0] q, hi_save;
    int dep;
    bit uf, st, flt, ps, pp;
    skip = 1'b0; exp_n = 0; exp_done = 0; exp_err = 0; exp_depth = 0;
    hi_save = exp_hi; dep = 0; cur = sa;
    if (sa[3:0] != 4'd0) begin exp_err = 1; return; end
    for (int step = 0; step < 32; step++) begin
      t = mem[cur[11:4]]; exp_hi = t[31:16];
      f = t[63:32]; q = t[15:0]; at = cur + 32'd16; ad = at + (32'(q) << 4);
      uf = 0; st = 0; flt = 0; ps = 0; pp = 0; da = at; nx = ad;
      case (t[30:28])
        3'd0: begin da = f; uf = 1; st = 1; end
        3'd1: ;
        3'd2: begin nx = f; uf = 1; end
        3'd3, 3'd4: begin da = f; nx = at; uf = 1; end
        3'd5: begin nx = f; uf = 1; if (dep == 2) flt = 1; else ps = 1; end
        3'd6: if (dep > 0) begin nx = stk[dep-1]; pp = 1; end else st = 1;
        default: st = 1;
      endcase
      if (uf && f[3:0] != 4'd0) flt = 1;
      if (flt) begin exp_err = 1; exp_depth = dep; return; end
      if (ps) begin stk[dep] = ad; dep++; end
      if (pp) dep--;
      if (t[31] && ie) st = 1;
      if (q != 16'd0) begin exp_a[exp_n] = da; exp_q[exp_n] = q; exp_n++; end
      exp_depth = dep;
      if (st) begin exp_done = 1; return; end
      cur = nx;
    end
    skip = 1'b1; exp_hi = hi_save;
  endtask

  task automatic run(input logic [31:0] sa, input bit ie, input string req, input bit poke);
    bit skip;
    int n;
    model(sa, ie, skip);
    if (skip) return;
    got_n = 0; seen = 1'b0;
    @(negedge clk);
    start_addr = sa; irq_en = ie; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 0;
    while ((busy || start) && n < 5000) begin
      @(negedge clk);
      start = 1'b0; n++;
      if (poke && n == 3 && busy) begin start = 1'b1; start_addr = 32'h40; end
    end
    check(n < 5000, req, "walk did not stop", n, 0);
    check(got_n == exp_n, req, "transfer count", got_n, exp_n);
    check(done == exp_done, req, "done flag (R10)", done, exp_done);
    check(error == exp_err, req, "error flag (R10)", error, exp_err);
    check(last_hi == exp_hi, "R9", "last descriptor upper half", last_hi, exp_hi);
    check(depth == 2'(exp_depth), "R5", "stack depth", depth, exp_depth);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = mk(7, 0, 32'h0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !error, "R1", "status after reset", {busy, done, error}, 0);
    check(!tag_req && !xfer_req, "R1", "requests after reset", {tag_req, xfer_req}, 0);
    check(depth == 2'd0 && last_hi == 16'd0, "R1", "depth and tag after reset", {depth, last_hi}, 0);

    // R4 count, jump, reference, stop
    mem[8'h10] = mk(1, 0, 32'h0, 2);
    mem[8'h13] = mk(2, 0, 32'h200, 0);
    mem[8'h20] = mk(3, 0, 32'h800, 1);
    mem[8'h21] = mk(7, 0, 32'h0, 1);
    run(32'h100, 0, "R4", 0);
    // R2 start address used for the first fetch: reference-stop alone
    mem[8'h50] = mk(0, 0, 32'h900, 3);
    run(32'h500, 0, "R2", 0);
    // R5 nested call and return, then return on empty stack
    clear_mem();
    mem[8'h30] = mk(5, 0, 32'h400, 1);
    mem[8'h40] = mk(5, 0, 32'h500, 0);
    mem[8'h50] = mk(6, 0, 32'h0, 1);
    mem[8'h41] = mk(6, 0, 32'h0, 0);
    mem[8'h32] = mk(6, 0, 32'h0, 2);
    run(32'h300, 0, "R5", 0);
    // R6 third nested call overflows
    mem[8'h60] = mk(5, 0, 32'h700, 1);
    mem[8'h70] = mk(5, 0, 32'h780, 0);
    mem[8'h78] = mk(5, 0, 32'h7c0, 2);
    run(32'h600, 0, "R6", 0);
    // R7 misaligned field and misaligned start
    mem[8'h80] = mk(1, 0, 32'h0, 1);
    mem[8'h82] = mk(3, 0, 32'h804, 2);
    run(32'h800, 0, "R7", 0);
    run(32'h108, 0, "R7", 0);
    // R8 interrupt flag with and without enable
    clear_mem();
    mem[8'h10] = mk(1, 1, 32'h0, 1);
    mem[8'h12] = mk(1, 0, 32'h0, 1);
    run(32'h100, 1, "R8", 0);
    run(32'h100, 0, "R8", 0);
    // R11 start pulse during a walk is ignored
    mem[8'h10] = mk(1, 0, 32'h0, 3);
    mem[8'h14] = mk(1, 0, 32'h0, 2);
    mem[8'h17] = mk(7, 0, 32'h0, 1);
    run(32'h100, 0, "R11", 1);
    // R3 zero-length descriptors issue no transfer
    clear_mem();
    mem[8'h10] = mk(1, 0, 32'h0, 0);
    mem[8'h11] = mk(4, 0, 32'hA00, 0);
    mem[8'h12] = mk(0, 0, 32'hA00, 0);
    run(32'h100, 0, "R3", 0);

    // random chains
    for (int it = 0; it < 80; it++) begin
      for (int i = 0; i < 256; i++) begin
        logic [31:0] f;
        f = {20'h0, 8'($urandom), 4'h0};
        if ($urandom % 16 == 0) f[3:0] = 4'($urandom | 1);
        mem[i] = {f, ($urandom % 10 == 0), 3'($urandom), 12'($urandom), 16'($urandom % 3)};
      end
      run({20'h0, 8'($urandom), 4'h0}, 1'($urandom), "R4", 1'($urandom % 4 == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule